// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block sequences one channel of a DMA engine that can walk linked descriptors. It takes the control bits that software writes (go, resume, cancel and a chained/direct selector), asks a descriptor memory port for list and link descriptors, and issues sub-block transfer requests to a shared transfer engine. It watches that engine's completion and error strobes, reports whether the channel is busy and whether it has failed, and decodes the control and status bits into a compact channel-state code.

In chained mode a run walks a list of list descriptors. Each list descriptor points to a chain of link descriptors, and each link descriptor stands for a fixed number of sub-block transfers. In direct mode a run is one group of sub-blocks with no descriptor traffic. After a chained run finishes, software can resume it. The channel then reads the last list descriptor again to pick up a next-list pointer that software may have changed. A channel can be stopped by clearing go, by a rising edge on cancel, or by a transfer error. In every case the channel stops issuing work and waits until nothing is in flight before it drops busy.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, busy and the error flag are 0, no descriptor or transfer request is raised, and the state code is 0 (idle).
- R2: In direct mode a rising edge of go issues exactly BLK_PER_DESC transfer requests and no descriptor request. Busy stays high until every one of them has completed. Transfer requests appear only while busy.
- R3: In chained mode a rising edge of go fetches the list descriptor at the programmed address first. It then fetches that list's link descriptors in turn, issuing BLK_PER_DESC transfers after each one. It moves to the next list when a link's end flag is set, and finishes after the list whose end-of-list flag is set.
- R4: The number of transfers in flight never exceeds MAX_OUT. Busy falls only when no transfer is in flight.
- R5: A rising edge of resume while idle-after-completion in chained mode fetches the current list descriptor again. If its end-of-list flag is still set, the channel returns to ready with no further fetch and no transfer.
- R6: If that re-read descriptor has its end-of-list flag clear, its next-list address becomes the current address and a second list fetch is made there. Both list fetches come before any link fetch or transfer.
- R7: Resume has no effect while idle, while halted on an error, or in direct mode.
- R8: Only a 0-to-1 change of cancel stops a busy channel. No new transfer is issued after it, and busy falls once the in-flight work has drained. A cancel level already held high when a run starts does not stop that run.
- R9: Clearing go while busy stops new transfers, drains, and leaves the channel halted with the error flag at 0.
- R10: A transfer error while busy sets the error flag, stops new work, and drains. The flag stays set until a write-one-to-clear pulse in the error-halted state. While it is set, go edges start nothing. After clearing, go starts runs again.
- R11: The state code is 6 when the error flag is set and not busy, and 5 when it is set and busy. Otherwise it is 3 when busy with go, 4 when busy without go, 2 when ready with go plus resume in chained mode, 1 when ready with go, and 0 when go is low.
- R12: desc_kind is 0 for a list fetch and 1 for a link fetch. A descriptor request and a transfer request are never raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Go level; a rising edge starts a run, a low level halts a busy run |
| cfg_continue | input | 1 | Resume; acts on its rising edge |
| cfg_abort | input | 1 | Cancel; acts on its rising edge |
| cfg_chain | input | 1 | 1 selects chained mode, 0 direct mode |
| cfg_list_addr | input | AW | First list descriptor address for a chained run |
| err_clr | input | 1 | Write-one-to-clear pulse for the error flag |
| desc_req | output | 1 | Descriptor fetch request, one cycle |
| desc_kind | output | 1 | 0 list fetch, 1 link fetch |
| desc_addr | output | AW | Descriptor address |
| desc_rsp_vld | input | 1 | Descriptor response valid |
| desc_rsp_next | input | AW | Next list address (list) or next link address (link) |
| desc_rsp_link | input | AW | First link address of a list descriptor |
| desc_rsp_eol | input | 1 | End of list (list) or last link (link) |
| xfer_req | output | 1 | Sub-block transfer request, one cycle each |
| xfer_done | input | 1 | One transfer completed |
| xfer_err | input | 1 | One transfer completed with an error |
| sts_busy | output | 1 | Channel busy |
| sts_terr | output | 1 | Sticky transfer-error flag |
| chan_view | output | 3 | Decoded channel-state code |

## Verification
The bench sweeps transfer latency and list length and counts every fetch and transfer by kind and by order. A design that skipped the re-read on resume, or fetched a link before the second list read, would show up in the event order. Cancel and go-low are applied mid-run, and the bench then checks that no further transfer appears and that nothing is left in flight when busy drops. A level-triggered cancel would instead kill the following run that starts with cancel held high. After an error, go and resume pulses are applied and checked to do nothing, so a non-sticky flag or a leaky start gate would produce transfers or a wrong state code.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_READY,
      S_HALT,
      S_ERRHALT,
      S_LREQ,
      S_LWAIT,
      S_CREQ,
      S_CWAIT,
      S_KREQ,
      S_KWAIT,
      S_XFER,
      S_DRAIN
   } chan_state_t;

   localparam logic [2:0] VIEW_IDLE        = 3'd0;
   localparam logic [2:0] VIEW_READY       = 3'd1;
   localparam logic [2:0] VIEW_CONTINUE    = 3'd2;
   localparam logic [2:0] VIEW_ACTIVE      = 3'd3;
   localparam logic [2:0] VIEW_SW_HALTING  = 3'd4;
   localparam logic [2:0] VIEW_ERR_HALTING = 3'd5;
   localparam logic [2:0] VIEW_ERR_HALTED  = 3'd6;

   localparam logic KIND_LIST = 1'b0;
   localparam logic KIND_LINK = 1'b1;

endpackage

// File: rtl/dma_rise_det.sv
module dma_rise_det #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev_q;
   end

endmodule

// File: rtl/dma_out_tracker.sv
module dma_out_tracker #(
   parameter int MAX_OUT = 4,
   localparam int CW     = $clog2(MAX_OUT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] cnt,
   output logic          full
);

   logic dec_ok;
   assign dec_ok = dec && (cnt != '0);
   assign full   = (cnt == CW'(MAX_OUT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         case ({inc, dec_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

endmodule

// File: rtl/dma_view_decode.sv
module dma_view_decode
   import dma_chan_pkg::*;
(
   input  logic       go,
   input  logic       busy,
   input  logic       terr,
   input  logic       resume,
   input  logic       chain,
   output logic [2:0] view
);

   always_comb begin
      if (terr)              view = busy ? VIEW_ERR_HALTING : VIEW_ERR_HALTED;
      else if (busy)         view = go ? VIEW_ACTIVE : VIEW_SW_HALTING;
      else if (!go)          view = VIEW_IDLE;
      else if (resume && chain) view = VIEW_CONTINUE;
      else                   view = VIEW_READY;
   end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_chan_pkg::*;
#(
   parameter int AW           = 16,
   parameter int BLK_PER_DESC = 4,
   parameter int MAX_OUT      = 4,
   parameter bit CHAIN_EN     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_start,
   input  logic          cfg_continue,
   input  logic          cfg_abort,
   input  logic          cfg_chain,
   input  logic [AW-1:0] cfg_list_addr,
   input  logic          err_clr,
   output logic          desc_req,
   output logic          desc_kind,
   output logic [AW-1:0] desc_addr,
   input  logic          desc_rsp_vld,
   input  logic [AW-1:0] desc_rsp_next,
   input  logic [AW-1:0] desc_rsp_link,
   input  logic          desc_rsp_eol,
   output logic          xfer_req,
   input  logic          xfer_done,
   input  logic          xfer_err,
   output logic          sts_busy,
   output logic          sts_terr,
   output logic [2:0]    chan_view
);

   localparam int CW = $clog2(MAX_OUT + 1);
   localparam int BW = $clog2(BLK_PER_DESC + 1);

   if (AW < 2) begin : g_bad_aw
      $error("AW must be at least 2");
   end
   if (BLK_PER_DESC < 1) begin : g_bad_blk
      $error("BLK_PER_DESC must be at least 1");
   end
   if (MAX_OUT < 1) begin : g_bad_out
      $error("MAX_OUT must be at least 1");
   end

   // chained mode can be compiled out
   logic chain_eff;
   if (CHAIN_EN) begin : g_chain
      assign chain_eff = cfg_chain;
   end else begin : g_direct
      assign chain_eff = 1'b0;
   end

   // control-bit edges: [2] cancel, [1] resume, [0] go
   logic [2:0] rise_v;
   logic       go_rise, cont_rise, abort_rise;

   dma_rise_det #(.W(3)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  ({cfg_abort, cfg_continue, cfg_start}),
      .rise (rise_v)
   );
   assign go_rise    = rise_v[0];
   assign cont_rise  = rise_v[1];
   assign abort_rise = rise_v[2];

   chan_state_t   state, drain_to;
   logic [AW-1:0] cur_list, lst_next, link_ptr, link_next;
   logic          lst_eol, link_eol, desc_pend, terr;
   logic [BW-1:0] blk_left;
   logic [CW-1:0] out_cnt;
   logic          out_full, busy_st, issue;

   dma_out_tracker #(.MAX_OUT(MAX_OUT)) u_track (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (issue),
      .dec  (xfer_done | xfer_err),
      .cnt  (out_cnt),
      .full (out_full)
   );

   always_comb begin
      case (state)
         S_LREQ, S_LWAIT, S_CREQ, S_CWAIT,
         S_KREQ, S_KWAIT, S_XFER, S_DRAIN: busy_st = 1'b1;
         default:                          busy_st = 1'b0;
      endcase
   end

   assign issue     = (state == S_XFER) && (blk_left != '0) && !out_full;
   assign xfer_req  = issue;
   assign desc_req  = (state == S_LREQ) || (state == S_CREQ) || (state == S_KREQ);
   assign desc_kind = (state == S_KREQ) ? KIND_LINK : KIND_LIST;
   assign desc_addr = (state == S_KREQ) ? link_ptr : cur_list;
   assign sts_busy  = busy_st;
   assign sts_terr  = terr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         drain_to  <= S_READY;
         cur_list  <= '0;
         lst_next  <= '0;
         link_ptr  <= '0;
         link_next <= '0;
         lst_eol   <= 1'b1;
         link_eol  <= 1'b1;
         desc_pend <= 1'b0;
         terr      <= 1'b0;
         blk_left  <= '0;
      end else begin
         if (desc_req)          desc_pend <= 1'b1;
         else if (desc_rsp_vld) desc_pend <= 1'b0;
         if (issue)             blk_left  <= blk_left - 1'b1;
         if (busy_st && xfer_err) terr <= 1'b1;

         case (state)
            S_IDLE, S_READY, S_HALT: begin
               if (go_rise && !terr) begin
                  cur_list <= cfg_list_addr;
                  if (chain_eff) begin
                     state <= S_LREQ;
                  end else begin
                     blk_left <= BW'(BLK_PER_DESC);
                     link_eol <= 1'b1;
                     lst_eol  <= 1'b1;
                     state    <= S_XFER;
                  end
               end else if (state == S_READY && cont_rise && chain_eff && cfg_start) begin
                  state <= S_CREQ;
               end
            end
            S_ERRHALT: begin
               if (err_clr) begin
                  terr  <= 1'b0;
                  state <= S_IDLE;
               end
            end
            default: begin
               if (xfer_err) begin
                  drain_to <= S_ERRHALT;
                  state    <= S_DRAIN;
               end else if (state != S_DRAIN && (abort_rise || !cfg_start)) begin
                  drain_to <= S_HALT;
                  state    <= S_DRAIN;
               end else begin
                  case (state)
                     S_LREQ: state <= S_LWAIT;
                     S_LWAIT: begin
                        if (desc_rsp_vld) begin
                           lst_next <= desc_rsp_next;
                           lst_eol  <= desc_rsp_eol;
                           link_ptr <= desc_rsp_link;
                           state    <= S_KREQ;
                        end
                     end
                     S_CREQ: state <= S_CWAIT;
                     S_CWAIT: begin
                        if (desc_rsp_vld) begin
                           if (desc_rsp_eol) begin
                              lst_eol <= 1'b1;
                              state   <= S_READY;
                           end else begin
                              cur_list <= desc_rsp_next;
                              state    <= S_LREQ;
                           end
                        end
                     end
                     S_KREQ: state <= S_KWAIT;
                     S_KWAIT: begin
                        if (desc_rsp_vld) begin
                           link_next <= desc_rsp_next;
                           link_eol  <= desc_rsp_eol;
                           blk_left  <= BW'(BLK_PER_DESC);
                           state     <= S_XFER;
                        end
                     end
                     S_XFER: begin
                        if (blk_left == '0) begin
                           if (!link_eol) begin
                              link_ptr <= link_next;
                              state    <= S_KREQ;
                           end else if (!lst_eol) begin
                              cur_list <= lst_next;
                              state    <= S_LREQ;
                           end else begin
                              drain_to <= S_READY;
                              state    <= S_DRAIN;
                           end
                        end
                     end
                     S_DRAIN: begin
                        if (out_cnt == '0 && !desc_pend) state <= drain_to;
                     end
                     default: state <= S_IDLE;
                  endcase
               end
            end
         endcase
      end
   end

   dma_view_decode u_view (
      .go    (cfg_start),
      .busy  (busy_st),
      .terr  (terr),
      .resume(cfg_continue),
      .chain (chain_eff),
      .view  (chan_view)
   );

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
   parameter int MAX_OUT = 4,
   localparam int CW     = $clog2(MAX_OUT + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_start,
   input logic          cfg_abort,
   input logic          err_clr,
   input logic          xfer_err,
   input logic          desc_req,
   input logic          xfer_req,
   input logic          sts_busy,
   input logic          sts_terr,
   input logic [CW-1:0] out_cnt
);

   assert_issue_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> sts_busy);

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_cnt <= CW'(MAX_OUT));

   assert_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_busy) |-> out_cnt == '0);

   assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sts_busy && cfg_abort && !$past(cfg_abort) |=> !xfer_req);

   assert_halt_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sts_busy && !cfg_start |=> !xfer_req);

   assert_terr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sts_terr && !err_clr |=> sts_terr);

   assert_terr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_terr) |-> $past(xfer_err));

   assert_terr_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sts_terr && !sts_busy |=> !sts_busy);

   assert_one_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(desc_req && xfer_req));

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.MAX_OUT(MAX_OUT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_start(cfg_start),
   .cfg_abort(cfg_abort),
   .err_clr  (err_clr),
   .xfer_err (xfer_err),
   .desc_req (desc_req),
   .xfer_req (xfer_req),
   .sts_busy (sts_busy),
   .sts_terr (sts_terr),
   .out_cnt  (out_cnt)
);

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;

   localparam int AW  = 8;
   localparam int BLK = 3;
   localparam int MO  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_start = 1'b0, cfg_continue = 1'b0, cfg_abort = 1'b0, cfg_chain = 1'b0;
   logic [AW-1:0] cfg_list_addr = '0;
   logic          err_clr = 1'b0;
   logic          desc_req, desc_kind;
   logic [AW-1:0] desc_addr;
   logic          desc_rsp_vld = 1'b0;
   logic [AW-1:0] desc_rsp_next = '0, desc_rsp_link = '0;
   logic          desc_rsp_eol = 1'b0;
   logic          xfer_req;
   logic          xfer_done = 1'b0, xfer_err = 1'b0;
   logic          sts_busy, sts_terr;
   logic [2:0]    chan_view;

   always #10 clk = ~clk;

   dma_chan_ctrl #(.AW(AW), .BLK_PER_DESC(BLK), .MAX_OUT(MO), .CHAIN_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_continue(cfg_continue),
      .cfg_abort(cfg_abort), .cfg_chain(cfg_chain), .cfg_list_addr(cfg_list_addr),
      .err_clr(err_clr), .desc_req(desc_req), .desc_kind(desc_kind), .desc_addr(desc_addr),
      .desc_rsp_vld(desc_rsp_vld), .desc_rsp_next(desc_rsp_next), .desc_rsp_link(desc_rsp_link),
      .desc_rsp_eol(desc_rsp_eol), .xfer_req(xfer_req), .xfer_done(xfer_done),
      .xfer_err(xfer_err), .sts_busy(sts_busy), .sts_terr(sts_terr), .chan_view(chan_view)
   );

   int nchk = 0, nerr = 0;
   int cyc = 0, lat = 1, list_last = 0;
   int n_list = 0, n_link = 0, n_xfer = 0, outst = 0, max_out = 0, n_ev = 0;
   int ev[0:31];
   int la[0:7];
   int q[$];
   bit err_next = 1'b0;
   bit dpend = 1'b0, dkind = 1'b0;
   logic [AW-1:0] daddr = '0;

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_log();
      n_list = 0; n_link = 0; n_xfer = 0; n_ev = 0; max_out = 0;
      for (int i = 0; i < 32; i++) ev[i] = -1;
      for (int i = 0; i < 8; i++) la[i] = -1;
   endtask

   // descriptor memory and transfer engine, acting at the falling edge
   task automatic responders();
      forever begin
         @(negedge clk);
         cyc++;
         desc_rsp_vld = 1'b0;
         if (dpend) begin
            desc_rsp_vld = 1'b1;
            if (dkind == 1'b0) begin
               desc_rsp_next = daddr + 8'd16;
               desc_rsp_link = daddr + 8'd1;
               desc_rsp_eol  = (int'(daddr) >= list_last);
            end else begin
               desc_rsp_next = daddr + 8'd1;
               desc_rsp_link = '0;
               desc_rsp_eol  = (daddr[3:0] == 4'd2);
            end
            dpend = 1'b0;
         end
         if (desc_req) begin
            dpend = 1'b1; dkind = desc_kind; daddr = desc_addr;
            if (n_ev < 32) ev[n_ev] = desc_kind ? 1 : 0;
            n_ev++;
            if (desc_kind) n_link++;
            else begin
               if (n_list < 8) la[n_list] = int'(desc_addr);
               n_list++;
            end
         end
         xfer_done = 1'b0; xfer_err = 1'b0;
         if (q.size() > 0 && q[0] <= cyc) begin
            void'(q.pop_front());
            if (err_next) begin xfer_err = 1'b1; err_next = 1'b0; end
            else xfer_done = 1'b1;
            outst--;
         end
         if (xfer_req) begin
            q.push_back(cyc + lat);
            n_xfer++; outst++;
            if (outst > max_out) max_out = outst;
            if (n_ev < 32) ev[n_ev] = 2;
            n_ev++;
         end
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #5;
      end
   endtask

   task automatic wait_idle(input string req);
      int t;
      t = 0;
      while (!sts_busy && t < 20) begin step(); t++; end
      t = 0;
      while (sts_busy && t < 3000) begin step(); t++; end
      if (sts_busy) chk({req, " run did not end"}, 1, 0);
   endtask

   task automatic go_edge();
      cfg_start = 1'b0; step(); cfg_start = 1'b1;
   endtask

   task automatic pulse_cont();
      cfg_continue = 1'b1; step(); cfg_continue = 1'b0;
   endtask

   initial begin
      int snap;
      fork
         responders();
         begin
            repeat (150000) @(posedge clk);
            nerr++;
            $display("FAIL watchdog: run hung, actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
         end
      join_none
      clear_log();
      step(3);
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 busy", int'(sts_busy), 0);
      chk("R1 terr", int'(sts_terr), 0);
      chk("R1 reqs", int'(desc_req) + int'(xfer_req), 0);
      chk("R1 R11 view idle", int'(chan_view), 0);

      // R7 resume while idle does nothing
      cfg_chain = 1'b1;
      pulse_cont(); step(5);
      chk("R7 idle resume fetch", n_list + n_link, 0);
      chk("R7 idle resume busy", int'(sts_busy), 0);

      // R2 direct-mode sweep over latency
      cfg_chain = 1'b0;
      for (int l = 1; l <= 4; l++) begin
         lat = l; clear_log();
         go_edge();
         step();
         chk("R11 active view", int'(chan_view), 3);
         wait_idle("R2");
         chk("R2 direct xfer count", n_xfer, BLK);
         chk("R2 direct no fetch", n_list + n_link, 0);
         chk("R4 max in flight", int'(max_out <= MO), 1);
         chk("R4 drained at idle", outst, 0);
      end
      chk("R11 ready view", int'(chan_view), 1);
      // R7 resume in direct mode ignored
      clear_log();
      cfg_continue = 1'b1; #1;
      chk("R11 direct resume view", int'(chan_view), 1);
      step(); cfg_continue = 1'b0; step(5);
      chk("R7 direct resume fetch", n_list, 0);
      chk("R7 direct resume busy", int'(sts_busy), 0);

      // R3 chained sweep: k lists of 2 links each
      cfg_chain = 1'b1; cfg_list_addr = 8'h10;
      for (int k = 1; k <= 3; k++) begin
         for (int l = 1; l <= 3; l++) begin
            lat = l; list_last = 16 * k; clear_log();
            go_edge();
            wait_idle("R3");
            chk("R3 lists", n_list, k);
            chk("R3 links", n_link, 2 * k);
            chk("R3 xfers", n_xfer, 2 * k * BLK);
            chk("R3 R12 first list addr", la[0], 16);
            chk("R3 R12 order list", ev[0], 0);
            chk("R3 R12 order link", ev[1], 1);
            chk("R3 order xfer", ev[2], 2);
            chk("R4 chain max in flight", int'(max_out <= MO), 1);
         end
      end

      // R5 resume with end-of-list still set; current list is 0x30
      lat = 2; list_last = 48; clear_log();
      cfg_continue = 1'b1; #1;
      chk("R11 continue view", int'(chan_view), 2);
      step(); cfg_continue = 1'b0;
      wait_idle("R5");
      chk("R5 one refetch", n_list, 1);
      chk("R5 refetch addr", la[0], 48);
      chk("R5 no link", n_link, 0);
      chk("R5 no xfer", n_xfer, 0);

      // R6 resume with end-of-list cleared
      list_last = 64; clear_log();
      pulse_cont();
      wait_idle("R6");
      chk("R6 list fetches", n_list, 2);
      chk("R6 first addr", la[0], 48);
      chk("R6 second addr", la[1], 64);
      chk("R6 order first", ev[0], 0);
      chk("R6 order second", ev[1], 0);
      chk("R6 order link", ev[2], 1);
      chk("R6 xfers", n_xfer, 2 * BLK);

      // R8 cancel on edge mid-run
      lat = 3; list_last = 48; clear_log();
      go_edge();
      while (n_xfer < 2) step();
      cfg_abort = 1'b1;
      @(negedge clk); #1;
      snap = n_xfer;
      wait_idle("R8");
      chk("R8 no xfer after cancel", n_xfer, snap);
      chk("R8 drained", outst, 0);
      chk("R8 no error", int'(sts_terr), 0);
      // R8 cancel level held: full run
      clear_log();
      go_edge();
      wait_idle("R8");
      chk("R8 level ignored xfers", n_xfer, 6 * BLK);
      cfg_abort = 1'b0;

      // R9 go cleared mid-run
      clear_log();
      go_edge();
      while (n_xfer < 2) step();
      cfg_start = 1'b0; #1;
      chk("R11 sw halting view", int'(chan_view), 4);
      @(negedge clk); #1;
      snap = n_xfer;
      wait_idle("R9");
      chk("R9 no xfer after halt", n_xfer, snap);
      chk("R9 drained", outst, 0);
      chk("R9 no error", int'(sts_terr), 0);

      // R10 transfer error in direct mode
      cfg_chain = 1'b0; lat = 2; err_next = 1'b1; clear_log();
      go_edge();
      wait_idle("R10");
      chk("R10 error flag", int'(sts_terr), 1);
      chk("R10 drained", outst, 0);
      chk("R11 error halted view", int'(chan_view), 6);
      snap = n_xfer;
      go_edge(); step(6);
      chk("R10 go ignored busy", int'(sts_busy), 0);
      chk("R10 go ignored xfer", n_xfer, snap);
      cfg_chain = 1'b1; clear_log();
      pulse_cont(); step(5);
      chk("R7 error resume fetch", n_list, 0);
      chk("R10 sticky", int'(sts_terr), 1);
      err_clr = 1'b1; step(); err_clr = 1'b0; step();
      chk("R10 cleared", int'(sts_terr), 0);
      chk("R11 ready after clear", int'(chan_view), 1);
      cfg_chain = 1'b0; clear_log();
      go_edge();
      wait_idle("R10");
      chk("R10 restart xfers", n_xfer, BLK);
      chk("R10 restart no error", int'(sts_terr), 0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule